// File: doc/BRIEF.md
# Half-Kernel Integer Gaussian Smoother

This block smooths an 8-bit greyscale image with a symmetric integer kernel. The kernel is defined by only four signed coefficients, called the half kernel. Element 0 is the centre tap, and elements 1, 2 and 3 are the taps at distances 1, 2 and 3. The same four values serve the taps on the left and on the right, with the order reversed on the left side. They also serve the taps above and below the pixel, because the vertical pass reads the stored intermediate image by columns instead of by rows. Each pass is therefore a 7-tap symmetric filter, and the two passes together give a separable 7x7 smoothing.

A frame of `IMG_W` x `IMG_H` pixels enters in raster order over a valid/ready input. The block then runs the horizontal pass over the stored frame, one pixel per cycle. Next it runs the vertical pass on the horizontal results and streams the smoothed pixels out in raster order over a valid/ready output. Pixels outside the image are replaced by the nearest edge pixel. Software must load half-kernel values whose weights add up to 2^`NORM_SHIFT`, and may load them only between frames.

Top module: `gauss_half_kernel`

## Requirements
- R1: After reset, `pix_ready_o` is 1, `out_valid_o` is 0, and the half kernel holds {20, 15, 6, 1} for elements 0 to 3.
- R2: The block accepts exactly `IMG_W*IMG_H` input pixels in raster order, one on each cycle with `pix_valid_i` and `pix_ready_o` both high. It then holds `pix_ready_o` low until the last output pixel has been accepted.
- R3: The horizontal result at (r,c) is the sum over o = -3..3 of k[|o|] times the input pixel at column c+o, where the column is clamped to 0..`IMG_W`-1. The left taps use k3, k2, k1, the mirror of the right taps k1, k2, k3.
- R4: The vertical result at (r,c) is the same 7-tap sum applied to the horizontal results down column c, with the row clamped to 0..`IMG_H`-1.
- R5: Each pass adds 2^(`NORM_SHIFT`-1) to its signed sum, shifts it arithmetically right by `NORM_SHIFT`, and clamps the result to 0..255. The horizontal result is stored as an 8-bit value.
- R6: Exactly `IMG_W*IMG_H` output pixels leave in raster order. While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged.
- R7: A cycle with `coef_we_i` high writes the signed value `coef_data_i` into half-kernel element `coef_idx_i` (0 = centre, 3 = outermost), but only while the block is idle: input phase with no pixel of the frame accepted yet. At any other time the write is ignored.
- R8: With the reset kernel, a frame of constant value v comes out as v at every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Half-kernel write strobe |
| coef_idx_i | input | 2 | Half-kernel element index |
| coef_data_i | input | COEF_W | Signed coefficient value |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Input pixel accepted when high with valid |
| pix_data_i | input | 8 | Input pixel |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Smoothed output pixel |

## Verification
The bound checker checks the handshake rules on every cycle. These are:
- the output hold under back-pressure;
- that the input and output phases never overlap;
- that the input closes after the frame's last pixel and reopens after the last output;
- that the half kernel stays frozen when a write arrives during a frame.

The values themselves can only be checked by the bench scenarios. A behavioural model of the two passes, with clamped edges, rounding and saturation, is compared against every output pixel. The image patterns are pseudo-random, flat, tile-checkered with a sharpening kernel that saturates at both ends, and corner impulses that exercise the edge replication. Output stalls and input gaps are random, and coefficient writes are attempted in the middle of a frame.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int PIX_W  = 8;
  localparam int HALF_N = 4;
  localparam int SPAN   = 2 * HALF_N - 1;
  localparam int CTR    = HALF_N - 1;

  typedef logic [PIX_W-1:0] pix_t;
  typedef enum logic [1:0] {PH_LOAD, PH_HOR, PH_VER} phase_e;
endpackage

// File: rtl/gk_coef_bank.sv
module gk_coef_bank
  import gk_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter logic [HALF_N-1:0][COEF_W-1:0] RST_COEF = '0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [$clog2(HALF_N)-1:0]        idx_i,
  input  logic [COEF_W-1:0]                data_i,
  input  logic                             idle_i,
  output logic [HALF_N-1:0][COEF_W-1:0]    coef_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_o <= RST_COEF;
    else if (we_i && idle_i) coef_o[idx_i] <= data_i;
  end
endmodule

// File: rtl/gk_tap_pass.sv
module gk_tap_pass
  import gk_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int SHIFT  = 6
) (
  input  pix_t [SPAN-1:0]                 taps_i,
  input  logic [HALF_N-1:0][COEF_W-1:0]   coef_i,
  output pix_t                            pix_o
);
  localparam int ACC_W = PIX_W + COEF_W + 4;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (SHIFT - 1);

  logic signed [ACC_W-1:0] term [HALF_N];
  logic signed [ACC_W-1:0] acc, scaled;

  // mirrored taps share one coefficient: pre-add the pair, one multiply
  for (genvar d = 0; d < HALF_N; d++) begin : g_term
    logic [PIX_W:0] psum;
    if (d == 0) begin : g_ctr
      assign psum = {1'b0, taps_i[CTR]};
    end else begin : g_pair
      assign psum = {1'b0, taps_i[CTR-d]} + {1'b0, taps_i[CTR+d]};
    end
    assign term[d] = ACC_W'($signed(coef_i[d])) * ACC_W'($signed({1'b0, psum}));
  end

  always_comb begin
    acc = HALF_LSB;
    for (int d = 0; d < HALF_N; d++) acc = acc + term[d];
    scaled = acc >>> SHIFT;
    if (scaled[ACC_W-1])               pix_o = '0;
    else if (|scaled[ACC_W-2:PIX_W])   pix_o = '1;
    else                               pix_o = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/gauss_half_kernel.sv
module gauss_half_kernel
  import gk_pkg::*;
#(
  parameter int IMG_W      = 16,
  parameter int IMG_H      = 12,
  parameter int COEF_W     = 8,
  parameter int NORM_SHIFT = 6,
  parameter logic [HALF_N-1:0][COEF_W-1:0] COEF_RESET =
    {COEF_W'(1), COEF_W'(6), COEF_W'(15), COEF_W'(20)}
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       coef_we_i,
  input  logic [$clog2(HALF_N)-1:0]  coef_idx_i,
  input  logic [COEF_W-1:0]          coef_data_i,
  input  logic                       pix_valid_i,
  output logic                       pix_ready_o,
  input  logic [PIX_W-1:0]           pix_data_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [PIX_W-1:0]           out_data_o
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int CW   = $clog2(IMG_W);
  localparam int RW   = $clog2(IMG_H);
  localparam int AW   = $clog2(NPIX);

  phase_e          phase_q, phase_nx;
  logic [CW-1:0]   col_q;
  logic [RW-1:0]   row_q;
  logic            last_col, last_row, step, idle;
  logic [AW-1:0]   cur_addr;

  pix_t fmem [NPIX];
  pix_t hmem [NPIX];
  pix_t [SPAN-1:0] h_taps, v_taps;
  pix_t h_pix, v_pix;

  logic [HALF_N-1:0][COEF_W-1:0] coef_q;

  assign last_col    = col_q == CW'(IMG_W - 1);
  assign last_row    = row_q == RW'(IMG_H - 1);
  assign pix_ready_o = phase_q == PH_LOAD;
  assign out_valid_o = phase_q == PH_VER;
  assign out_data_o  = v_pix;
  assign idle        = (phase_q == PH_LOAD) && (col_q == '0) && (row_q == '0);
  assign cur_addr    = AW'(int'(row_q) * IMG_W + int'(col_q));

  always_comb begin
    unique case (phase_q)
      PH_LOAD: step = pix_valid_i;
      PH_HOR:  step = 1'b1;
      PH_VER:  step = out_ready_i;
      default: step = 1'b0;
    endcase
    unique case (phase_q)
      PH_LOAD: phase_nx = PH_HOR;
      PH_HOR:  phase_nx = PH_VER;
      default: phase_nx = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      col_q   <= '0;
      row_q   <= '0;
    end else if (step) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= last_row ? '0 : row_q + 1'b1;
        if (last_row) phase_q <= phase_nx;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (phase_q == PH_LOAD && pix_valid_i) fmem[cur_addr] <= pix_data_i;
    if (phase_q == PH_HOR)                 hmem[cur_addr] <= h_pix;
  end

  // row taps read the input frame; column taps read the stored horizontal result
  for (genvar t = 0; t < SPAN; t++) begin : g_tap
    localparam int OFS = t - CTR;
    int hc, vr;
    always_comb begin
      hc = int'(col_q) + OFS;
      if (hc < 0) hc = 0;
      else if (hc > IMG_W - 1) hc = IMG_W - 1;
      vr = int'(row_q) + OFS;
      if (vr < 0) vr = 0;
      else if (vr > IMG_H - 1) vr = IMG_H - 1;
    end
    assign h_taps[t] = fmem[AW'(int'(row_q) * IMG_W + hc)];
    assign v_taps[t] = hmem[AW'(vr * IMG_W + int'(col_q))];
  end

  gk_coef_bank #(.COEF_W(COEF_W), .RST_COEF(COEF_RESET)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_we_i),
    .idx_i  (coef_idx_i),
    .data_i (coef_data_i),
    .idle_i (idle),
    .coef_o (coef_q)
  );

  gk_tap_pass #(.COEF_W(COEF_W), .SHIFT(NORM_SHIFT)) u_hpass (
    .taps_i (h_taps),
    .coef_i (coef_q),
    .pix_o  (h_pix)
  );

  gk_tap_pass #(.COEF_W(COEF_W), .SHIFT(NORM_SHIFT)) u_vpass (
    .taps_i (v_taps),
    .coef_i (coef_q),
    .pix_o  (v_pix)
  );
endmodule

// File: rtl/gk_checker.sv
module gk_checker #(
  parameter int NPIX   = 192,
  parameter int COEF_W = 8
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   pix_valid_i,
  input logic                                   pix_ready_o,
  input logic                                   out_valid_o,
  input logic                                   out_ready_i,
  input logic [7:0]                             out_data_o,
  input logic                                   coef_we_i,
  input logic [gk_pkg::HALF_N-1:0][COEF_W-1:0]  coef_q
);
  logic [31:0] in_cnt, out_cnt;
  logic        busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (pix_valid_i && pix_ready_o)
        in_cnt <= (in_cnt == 32'(NPIX - 1)) ? '0 : in_cnt + 1;
      if (out_valid_o && out_ready_i)
        out_cnt <= (out_cnt == 32'(NPIX - 1)) ? '0 : out_cnt + 1;
    end
  end

  assign busy = !pix_ready_o || (in_cnt != '0);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_phase_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> !out_valid_o);

  p_in_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cnt == 32'(NPIX - 1)) && pix_valid_i && pix_ready_o |=> !pix_ready_o);

  p_in_reopen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt == 32'(NPIX - 1)) && out_valid_o && out_ready_i |=> pix_ready_o && !out_valid_o);

  p_coef_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_i && busy |=> $stable(coef_q));
endmodule

bind gauss_half_kernel gk_checker #(.NPIX(IMG_W * IMG_H), .COEF_W(COEF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .pix_ready_o (pix_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .coef_we_i   (coef_we_i),
  .coef_q      (coef_q)
);

// File: tb/gauss_half_kernel_tb.sv
module gauss_half_kernel_tb;
  localparam int W  = 16;
  localparam int H  = 12;
  localparam int N  = W * H;
  localparam int SH = 6;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       coef_we_i = 0;
  logic [1:0] coef_idx_i = 0;
  logic [7:0] coef_data_i = 0;
  logic       pix_valid_i = 0;
  logic       pix_ready_o;
  logic [7:0] pix_data_i = 0;
  logic       out_valid_o;
  logic       out_ready_i = 1;
  logic [7:0] out_data_o;

  int checks = 0, errors = 0;
  int img [N];
  int hbuf [N];
  int expv [N];
  int kc [4];
  int out_idx = 0;
  int flat_val = -1;
  bit stall_en = 0;
  int unsigned seed = 32'h1234_5678;
  bit prev_stall = 0;
  logic [7:0] prev_data = 0;

  always #2.5 clk_i = ~clk_i;

  gauss_half_kernel #(.IMG_W(W), .IMG_H(H), .COEF_W(8), .NORM_SHIFT(SH)) u_dut (
    .clk_i, .rst_ni, .coef_we_i, .coef_idx_i, .coef_data_i,
    .pix_valid_i, .pix_ready_o, .pix_data_i,
    .out_valid_o, .out_ready_i, .out_data_o
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int norm(int acc);
    return clip((acc + (1 << (SH - 1))) >>> SH, 0, 255);
  endfunction

  task automatic build_ref();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int s = 0;
        for (int o = -3; o <= 3; o++) s += kc[o < 0 ? -o : o] * img[r*W + clip(c+o, 0, W-1)];
        hbuf[r*W + c] = norm(s);
      end
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int s = 0;
        for (int o = -3; o <= 3; o++) s += kc[o < 0 ? -o : o] * hbuf[clip(r+o, 0, H-1)*W + c];
        expv[r*W + c] = norm(s);
      end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // output monitor, compared on every clock
  always @(negedge clk_i) if (rst_ni) begin
    if (prev_stall) begin
      check(out_valid_o, "R6 valid held under stall", int'(out_valid_o), 1);
      check(out_data_o == prev_data, "R6 data held under stall", int'(out_data_o), int'(prev_data));
    end
    if (out_valid_o && out_ready_i) begin
      if (out_idx < N) begin
        check(int'(out_data_o) == expv[out_idx], "R3 R4 R5 smoothed pixel", int'(out_data_o), expv[out_idx]);
        if (flat_val >= 0) check(int'(out_data_o) == flat_val, "R8 flat field", int'(out_data_o), flat_val);
      end else begin
        check(0, "R6 extra output", out_idx, N - 1);
      end
      out_idx++;
    end
    prev_stall = out_valid_o && !out_ready_i;
    prev_data  = out_data_o;
  end

  always @(posedge clk_i) begin
    #1;
    out_ready_i = stall_en ? ((rnd() % 3) != 0) : 1'b1;
  end

  task automatic write_coef(int idx, int val);
    @(posedge clk_i); #1;
    coef_we_i = 1; coef_idx_i = 2'(idx); coef_data_i = 8'(val);
    @(posedge clk_i); #1;
    coef_we_i = 0;
  endtask

  task automatic run_frame(int poke_at, bit poke_out, bit gaps);
    bit ok;
    build_ref();
    out_idx = 0;
    for (int i = 0; i < N; i++) begin
      if (gaps && (rnd() % 4 == 0)) begin
        @(posedge clk_i); #1; pix_valid_i = 0; coef_we_i = 0;
      end
      @(posedge clk_i); #1;
      pix_valid_i = 1; pix_data_i = 8'(img[i]);
      coef_we_i = (i == poke_at); coef_idx_i = 0; coef_data_i = 8'd99;
      ok = 0;
      while (!ok) begin
        @(negedge clk_i); ok = pix_ready_o;
        if (!ok) begin @(posedge clk_i); #1; coef_we_i = 0; end
      end
    end
    @(posedge clk_i); #1; pix_valid_i = 0; coef_we_i = 0;
    @(negedge clk_i);
    check(!pix_ready_o, "R2 input closed after full frame", int'(pix_ready_o), 0);
    if (poke_out) begin
      write_coef(1, 77);  // R7: ignored outside idle
      write_coef(3, 55);
    end
    while (out_idx < N) @(negedge clk_i);
    @(negedge clk_i);
    check(pix_ready_o && !out_valid_o, "R2 R6 input reopens after last output",
          int'(pix_ready_o), 1);
    check(out_idx == N, "R6 output count", out_idx, N);
  endtask

  task automatic main();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(pix_ready_o, "R1 reset pix_ready", int'(pix_ready_o), 1);
    check(!out_valid_o, "R1 reset out_valid", int'(out_valid_o), 0);
    #1 rst_ni = 1;

    // frame 1: reset kernel, random image, stalls, gaps, mid-load write (R1, R7)
    kc = '{20, 15, 6, 1};
    for (int i = 0; i < N; i++) img[i] = int'(rnd() % 256);
    stall_en = 1;
    run_frame(5, 0, 1);

    // frame 2: flat field (R8)
    for (int i = 0; i < N; i++) img[i] = 200;
    flat_val = 200; stall_en = 0;
    run_frame(-1, 0, 0);
    flat_val = -1;

    // frame 3: sharpening kernel with negative tap, tile checker -> saturation (R5, R7)
    write_coef(0, 40); write_coef(1, 16); write_coef(2, -6); write_coef(3, 2);
    kc = '{40, 16, -6, 2};
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r*W + c] = (((r >> 2) + (c >> 2)) % 2) ? 255 : 0;
    stall_en = 1;
    run_frame(N - 1, 1, 1);

    // frame 4: impulses at corners, edge replication (R3, R4)
    write_coef(0, 32); write_coef(1, 16); write_coef(2, 0); write_coef(3, 0);
    kc = '{32, 16, 0, 0};
    for (int i = 0; i < N; i++) img[i] = 0;
    img[0] = 255; img[N - 1] = 128; img[W - 1] = 90;
    run_frame(-1, 0, 0);
  endtask

  initial begin
    fork
      main();
      begin
        repeat (150000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule